// File: doc/BRIEF.md
# Clock-Enable Pattern Flag with Cross-Domain Up/Down Tally

This block keeps slow-rate control logic inside the fast system clock domain. A free-running modulo divider emits a single-cycle tick every `DIV` system clocks, for example a 250 kHz tick from a 25 MHz clock with the default of 100. Only on tick cycles does a one-bit match flag react to the byte-received strobe. When the strobe is high, the flag records whether the presented byte equals the fixed pattern 8'b1010_1010 (8'hAA). When the strobe is low, the flag keeps its value.

The flag is consumed in a second, unrelated clock domain. It passes through a chain of two flip-flops clocked by the destination clock. A 16-bit tally register in that domain steps up by one on every destination edge while the synchronized flag is 1, and steps down by one while it is 0. The tally wraps modulo 2^16 in both directions. Each domain has its own synchronous, active-high reset.

The byte source is outside this block. The strobe and the byte only need to be valid on tick cycles.

Top module: `pattern_tally`

## Requirements
- R1: After the first tick, `tick_o` is high for exactly one system cycle in every `DIV` (default 100) system cycles, and it is never high on two consecutive cycles.
- R2: After `rst_sys` is released, the divider starts counting from zero. The first tick appears on the system cycle that follows the 99th rising edge after release (`DIV`-1 edges).
- R3: A rising system edge that sees `tick_o`=1, `rx_valid`=1 and `rx_byte`=8'hAA sets `match_o` to 1 for the next cycle.
- R4: A rising system edge that sees `tick_o`=1, `rx_valid`=1 and any byte other than 8'hAA clears `match_o` to 0.
- R5: While `tick_o` is 0, `rx_valid` and `rx_byte` have no effect on `match_o`.
- R6: A tick with `rx_valid`=0 leaves `match_o` unchanged, whatever the value of `rx_byte`.
- R7: `rst_sys` high at a rising system edge clears `match_o` and the divider, so `tick_o` is 0 during reset.
- R8: `rst_dst` high at a rising destination edge clears `tally_o` and both synchronizer stages to 0.
- R9: On each destination edge without reset, `tally_o` changes by +1 when the second synchronizer stage holds 1, and by -1 when it holds 0. A change of `match_o` therefore first changes the step direction on the third destination edge after it.
- R10: `tally_o` wraps from 16'hFFFF to 16'h0000 when stepping up, and from 16'h0000 to 16'hFFFF when stepping down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_sys | input | 1 | Synchronous active-high reset, system domain |
| rx_valid | input | 1 | Byte-received strobe, sampled on tick cycles |
| rx_byte | input | 8 | Received byte, sampled on tick cycles |
| clk_dst | input | 1 | Destination clock |
| rst_dst | input | 1 | Synchronous active-high reset, destination domain |
| tick_o | output | 1 | One-cycle clock-enable pulse from the divider |
| match_o | output | 1 | Pattern match flag (system domain) |
| tally_o | output | 16 | Up/down tally (destination domain) |

## Verification
`tick_o` depends only on a registered count, so it is sampled at the falling system edge of the same cycle the count reaches `DIV`-1. `match_o` is due one system edge after the tick cycle on which the byte is presented, so each table entry waits for the tick and then samples at the next falling edge. `tally_o` lags a flag change by two synchronizer edges plus one counter edge. The bench runs a reference of that three-edge path in the destination clock and compares at every falling destination edge. The two clocks are phased so that their rising edges never coincide, which keeps the reference deterministic.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int unsigned BYTE_W          = 8;
    typedef logic [BYTE_W-1:0] byte_t;
    localparam byte_t       MATCH_PATTERN   = 8'b1010_1010;
    localparam int unsigned DEFAULT_DIV     = 100;
    localparam int unsigned DEFAULT_TALLY_W = 16;
    localparam int unsigned DEFAULT_SYNC_N  = 2;
endpackage

// File: rtl/pt_rate_tick.sv
module pt_rate_tick #(
    parameter int unsigned DIV = pt_pkg::DEFAULT_DIV
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_st_t;

    div_st_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (div_q.cnt == LAST) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign tick_o = (div_q.cnt == LAST);

    AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_o |=> !tick_o); // R1
    AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        div_q.cnt <= LAST); // R1
endmodule

// File: rtl/pt_match_flag.sv
module pt_match_flag #(
    parameter pt_pkg::byte_t PATTERN = pt_pkg::MATCH_PATTERN
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          tick_i,
    input  logic          stb_i,
    input  pt_pkg::byte_t data_i,
    output logic          flag_o
);
    typedef struct packed {
        logic flag;
    } flag_st_t;

    flag_st_t flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (tick_i && stb_i) begin
            flag_d.flag = (data_i == PATTERN);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q.flag;

    AST_FLAG_HIT: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && stb_i && data_i == PATTERN) |=> flag_o); // R3
    AST_FLAG_MISS: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && stb_i && data_i != PATTERN) |=> !flag_o); // R4
    AST_FLAG_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> $stable(flag_o)); // R5
    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && !stb_i) |=> $stable(flag_o)); // R6
endmodule

// File: rtl/pt_flag_sync.sv
module pt_flag_sync #(
    parameter int unsigned STAGES = pt_pkg::DEFAULT_SYNC_N
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_st_t;

    sync_st_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.pipe = {sync_q.pipe[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.pipe[STAGES-1];

    for (genvar g = 1; g < STAGES; g++) begin : g_shift_chk
        AST_SYNC_SHIFT: assert property (@(posedge clk_i) disable iff (rst_i)
            1'b1 |=> (sync_q.pipe[g] == $past(sync_q.pipe[g-1]))); // R9
    end
endmodule

// File: rtl/pt_updown_tally.sv
module pt_updown_tally #(
    parameter int unsigned W = pt_pkg::DEFAULT_TALLY_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         up_i,
    output logic [W-1:0] tally_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } tally_st_t;

    tally_st_t tally_d, tally_q;

    always_comb begin
        tally_d = tally_q;
        if (up_i) begin
            tally_d.cnt = tally_q.cnt + W'(1);
        end else begin
            tally_d.cnt = tally_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tally_q <= '0;
        end else begin
            tally_q <= tally_d;
        end
    end

    assign tally_o = tally_q.cnt;

    AST_TALLY_UP: assert property (@(posedge clk_i) disable iff (rst_i)
        up_i |=> (tally_o == W'($past(tally_o) + W'(1)))); // R10
    AST_TALLY_DOWN: assert property (@(posedge clk_i) disable iff (rst_i)
        !up_i |=> (tally_o == W'($past(tally_o) - W'(1)))); // R9
endmodule

// File: rtl/pattern_tally.sv
module pattern_tally #(
    parameter int unsigned DIV     = pt_pkg::DEFAULT_DIV,
    parameter int unsigned TALLY_W = pt_pkg::DEFAULT_TALLY_W
) (
    input  logic               clk_sys,
    input  logic               rst_sys,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    input  logic               clk_dst,
    input  logic               rst_dst,
    output logic               tick_o,
    output logic               match_o,
    output logic [TALLY_W-1:0] tally_o
);
    logic tick_w;
    logic flag_w;
    logic flag_dst_w;

    pt_rate_tick #(.DIV(DIV)) u_tick (
        .clk_i  (clk_sys),
        .rst_i  (rst_sys),
        .tick_o (tick_w)
    );

    pt_match_flag #(.PATTERN(pt_pkg::MATCH_PATTERN)) u_flag (
        .clk_i  (clk_sys),
        .rst_i  (rst_sys),
        .tick_i (tick_w),
        .stb_i  (rx_valid),
        .data_i (rx_byte),
        .flag_o (flag_w)
    );

    pt_flag_sync #(.STAGES(pt_pkg::DEFAULT_SYNC_N)) u_sync (
        .clk_i   (clk_dst),
        .rst_i   (rst_dst),
        .async_i (flag_w),
        .sync_o  (flag_dst_w)
    );

    pt_updown_tally #(.W(TALLY_W)) u_tally (
        .clk_i   (clk_dst),
        .rst_i   (rst_dst),
        .up_i    (flag_dst_w),
        .tally_o (tally_o)
    );

    assign tick_o  = tick_w;
    assign match_o = flag_w;
endmodule

// File: tb/tb_pattern_tally.sv
module tb_pattern_tally;
    logic        clk_sys = 1'b0;
    logic        clk_dst = 1'b0;
    logic        rst_sys = 1'b1;
    logic        rst_dst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tick_o;
    logic        match_o;
    logic [15:0] tally_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_en  = 1'b0;
    bit done    = 1'b0;

    pattern_tally dut (
        .clk_sys  (clk_sys),
        .rst_sys  (rst_sys),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .clk_dst  (clk_dst),
        .rst_dst  (rst_dst),
        .tick_o   (tick_o),
        .match_o  (match_o),
        .tally_o  (tally_o)
    );

    // 50 MHz system clock: rising edges at 10 + 20k ns
    always #10 clk_sys = ~clk_sys;
    // destination clock: rising edges at 3 + 14k ns, never on a system rising edge
    initial begin
        #3;
        forever begin
            clk_dst = 1'b1; #7;
            clk_dst = 1'b0; #7;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model built from the requirements
    int          m_div = 0;
    logic        m_flag = 1'b0;
    logic        m_s1 = 1'b0, m_s2 = 1'b0;
    logic [15:0] m_cnt = 16'h0;
    logic [15:0] m_prev = 16'h0;

    always @(posedge clk_sys) begin
        if (rst_sys) begin
            m_div  <= 0;
            m_flag <= 1'b0;
        end else if (m_div == 99) begin
            m_div <= 0;
            if (rx_valid) m_flag <= (rx_byte == 8'hAA);
        end else begin
            m_div <= m_div + 1;
        end
    end

    always @(posedge clk_dst) begin
        m_prev <= m_cnt;
        if (rst_dst) begin
            m_s1 <= 1'b0; m_s2 <= 1'b0; m_cnt <= 16'h0;
        end else begin
            m_s1  <= m_flag;
            m_s2  <= m_s1;
            m_cnt <= m_s2 ? m_cnt + 16'd1 : m_cnt - 16'd1;
        end
    end

    // continuous comparisons
    int gap  = 0;
    bit seen = 1'b0;
    always @(negedge clk_sys) begin
        if (cmp_en) begin
            check(match_o == m_flag, "R3/R4 flag", match_o, m_flag);
            check(tick_o == (m_div == 99), "R1 tick", tick_o, (m_div == 99));
        end
        if (rst_sys) begin
            gap = 0; seen = 1'b0;
        end else begin
            gap++;
            if (tick_o) begin
                if (seen) check(gap == 100, "R1 spacing", gap, 100);
                seen = 1'b1; gap = 0;
            end
        end
    end

    always @(negedge clk_dst) begin
        if (cmp_en) begin
            check(tally_o == m_cnt, "R9 tally", tally_o, m_cnt);
            if (!rst_dst && m_prev == 16'hFFFF && m_cnt == 16'h0000)
                check(tally_o == 16'h0000, "R10 up wrap", tally_o, 0);
        end
    end

    // table: {strobe, byte, expected flag}
    localparam int NV = 8;
    localparam logic [9:0] VEC [NV] = '{
        {1'b1, 8'hAA, 1'b1},
        {1'b1, 8'hAB, 1'b0},
        {1'b1, 8'hAA, 1'b1},
        {1'b0, 8'h00, 1'b1},
        {1'b1, 8'h55, 1'b0},
        {1'b0, 8'hAA, 1'b0},
        {1'b1, 8'h2A, 1'b0},
        {1'b1, 8'hAA, 1'b1}
    };

    task automatic wait_tick_then_one();
        while (!tick_o) @(negedge clk_sys);
        @(negedge clk_sys);
    endtask

    task automatic first_tick_check(input string req);
        int n = 0;
        while (1) begin
            @(negedge clk_sys);
            n++;
            if (tick_o || n > 200) break;
        end
        check(n == 99, req, n, 99);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk_sys);
        check(match_o == 1'b0, "R7 reset flag", match_o, 0);
        check(tick_o == 1'b0, "R7 reset tick", tick_o, 0);
        check(tally_o == 16'h0, "R8 reset tally", tally_o, 0);

        rst_sys = 1'b0;
        rst_dst = 1'b0;
        cmp_en  = 1'b1;
        first_tick_check("R2 first tick");

        for (int i = 0; i < NV; i++) begin
            rx_valid = VEC[i][9];
            rx_byte  = VEC[i][8:1];
            wait_tick_then_one();
            check(match_o == VEC[i][0], VEC[i][9] ? "R3/R4 table" : "R6 table",
                  match_o, VEC[i][0]);
        end

        // R5: strobe and mismatching byte away from the tick do nothing
        rx_valid = 1'b1;
        rx_byte  = 8'h00;
        repeat (40) @(negedge clk_sys);
        check(match_o == 1'b1, "R5 off-tick strobe", match_o, 1);
        rx_valid = 1'b0;
        wait_tick_then_one();
        check(match_o == 1'b1, "R5 after tick", match_o, 1);

        // R7: mid-run reset of the system domain
        rst_sys = 1'b1;
        @(negedge clk_sys);
        check(match_o == 1'b0, "R7 mid reset flag", match_o, 0);
        check(tick_o == 1'b0, "R7 mid reset tick", tick_o, 0);
        rst_sys = 1'b0;
        first_tick_check("R2 restart");

        // random byte stream
        for (int k = 0; k < 300; k++) begin
            rx_valid = (($urandom % 4) != 0);
            rx_byte  = (($urandom % 3) == 0) ? 8'hAA : 8'($urandom);
            wait_tick_then_one();
        end

        // destination corner: flag held at 1, then destination reset
        rx_valid = 1'b1;
        rx_byte  = 8'hAA;
        wait_tick_then_one();
        rx_valid = 1'b0;
        @(negedge clk_dst);
        rst_dst = 1'b1;
        repeat (2) @(negedge clk_dst);
        check(tally_o == 16'h0, "R8 dst reset", tally_o, 0);
        rst_dst = 1'b0;
        @(negedge clk_dst);
        check(tally_o == 16'hFFFF, "R10 down wrap", tally_o, 16'hFFFF);
        @(negedge clk_dst);
        check(tally_o == 16'hFFFE, "R9 sync latency", tally_o, 16'hFFFE);
        @(negedge clk_dst);
        check(tally_o == 16'hFFFF, "R9 first up step", tally_o, 16'hFFFF);
        @(negedge clk_dst);
        check(tally_o == 16'h0000, "R10 up wrap", tally_o, 0);

        repeat (4) @(negedge clk_dst);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule